// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a synchronous request interface and an 8K x 8 asynchronous static RAM. It has two chip selects of opposite polarity, an active-low write enable, an active-low output enable and one shared data bus. A client presents a single-cycle read or write request with a valid/ready handshake. The sequencer captures the address and data, holds them on the memory pins, and steps the strobes through a fixed pattern. Each phase of that pattern lasts a number of clock cycles set by a parameter.

Each timing window is a parameter counted in clock cycles. The integrator rounds each nanosecond minimum up at the chosen clock period. The windows are the read access time, the write pulse (which also covers address-valid and select-to-end-of-write), the post-write recovery and the bus turnaround. A read returns its byte with a one-cycle valid pulse. A write reports completion with a one-cycle done pulse. Between requests the memory is parked in power-down with its data pins floating. The bidirectional bus appears as separate output, output-enable and input pins, so the pad ring can supply the tri-state buffer.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, and in every cycle in which `req_ready` is high, the memory is in power-down: `mem_cs_n`=1, `mem_cs`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0.
- R2: A request is taken only on a cycle with `req_valid` and `req_ready` both high. `req_ready` is low from the cycle after acceptance until the strobes are back at idle. A `req_valid` raised while busy has no effect.
- R3: `mem_addr` takes the request address in the cycle after acceptance and keeps it until `req_ready` returns high.
- R4: A write (`req_write`=1) starts with one setup cycle. In that cycle both selects are asserted, `mem_we_n`=1 and the data is driven. Then `mem_we_n` is low for exactly `T_WP` cycles, with the data driven and unchanged.
- R5: `mem_dq_oe` is high only in the write setup cycle and the `mem_we_n`-low cycles. It is never high while `mem_oe_n` is low.
- R6: Whenever `mem_we_n` or `mem_oe_n` is low, both selects are asserted. `mem_we_n` and `mem_oe_n` are never low together.
- R7: A read (`req_write`=0) holds `mem_oe_n` low with both selects asserted for exactly `T_ACC` cycles. The bus is sampled in the last of those cycles. `rd_data` carries that byte with `rd_valid` high for exactly the one cycle after `mem_oe_n` rises.
- R8: `wr_done` is high for exactly the one cycle after `mem_we_n` rises.
- R9: After a read, `req_ready` returns `T_TURN` cycles after the `rd_valid` cycle begins. After a write, it returns max(`T_WREC`,`T_TURN`) cycles after the `wr_done` cycle begins. At least `T_TURN` quiet cycles always separate the controller driving the bus from the memory driving it, in either order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write byte |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` valid |
| rd_data | output | DATA_W | Byte read from memory |
| wr_done | output | 1 | One-cycle pulse: write finished |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_o | output | DATA_W | Data to the pad |
| mem_dq_oe | output | 1 | Pad output enable |
| mem_dq_i | input | DATA_W | Data from the pad |

## Verification
Counting from the edge that accepts a write, the setup cycle is cycle 1 and `mem_we_n` is low in cycles 2 to `T_WP`+1. `wr_done` appears in cycle `T_WP`+2 and `req_ready` comes back max(`T_WREC`,`T_TURN`) cycles later. For a read, `mem_oe_n` is low in cycles 1 to `T_ACC`, `rd_valid` is due in cycle `T_ACC`+1 and `req_ready` returns `T_TURN` cycles after that. The bench drives and samples on falling edges and steps one falling edge per cycle through that count, checking every cycle of each window. The memory model returns wrong data before `T_ACC` cycles of output enable have passed, so a sample taken early or late is caught.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_WSET   = 3'd1,
      ST_WPULSE = 3'd2,
      ST_WREC   = 3'd3,
      ST_RACC   = 3'd4,
      ST_RTURN  = 3'd5
   } seq_state_t;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_win_timer.sv
module sram_win_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_strobe_pkg::*;
#(
   parameter int CNT_W   = 4,
   parameter int T_ACC   = 7,
   parameter int T_WP    = 6,
   parameter int POST_WR = 4,
   parameter int T_TURN  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             expired,
   output seq_state_t       nxt_state,
   output logic             load,
   output logic [CNT_W-1:0] load_val,
   output logic             accept,
   output logic             rd_capture,
   output logic             wr_end
);
   seq_state_t state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= nxt_state;
   end

   always_comb begin
      nxt_state = state_q;
      load      = 1'b0;
      load_val  = '0;
      case (state_q)
         ST_IDLE: if (req_valid) begin
            load = 1'b1;
            if (req_write) begin
               nxt_state = ST_WSET;
               load_val  = '0;
            end else begin
               nxt_state = ST_RACC;
               load_val  = CNT_W'(T_ACC - 1);
            end
         end
         ST_WSET: if (expired) begin
            nxt_state = ST_WPULSE;
            load      = 1'b1;
            load_val  = CNT_W'(T_WP - 1);
         end
         ST_WPULSE: if (expired) begin
            nxt_state = ST_WREC;
            load      = 1'b1;
            load_val  = CNT_W'(POST_WR - 1);
         end
         ST_RACC: if (expired) begin
            nxt_state = ST_RTURN;
            load      = 1'b1;
            load_val  = CNT_W'(T_TURN - 1);
         end
         ST_WREC, ST_RTURN: if (expired) nxt_state = ST_IDLE;
         default: nxt_state = ST_IDLE;
      endcase
   end

   assign accept     = (state_q == ST_IDLE) && req_valid;
   assign rd_capture = (state_q == ST_RACC) && expired;
   assign wr_end     = (state_q == ST_WPULSE) && expired;
endmodule

// File: rtl/sram_pin_stage.sv
module sram_pin_stage
   import sram_strobe_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  seq_state_t        nxt_state,
   input  logic              accept,
   input  logic              rd_capture,
   input  logic              wr_end,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] mem_dq_i,
   output logic              req_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_cs,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              wr_done
);
   logic sel_d;
   assign sel_d = (nxt_state == ST_WSET) || (nxt_state == ST_WPULSE) ||
                  (nxt_state == ST_RACC);

   // strobes come straight from flops so the pins never glitch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_ready <= 1'b1;
         mem_cs_n  <= 1'b1;
         mem_cs    <= 1'b0;
         mem_we_n  <= 1'b1;
         mem_oe_n  <= 1'b1;
         mem_dq_oe <= 1'b0;
         rd_valid  <= 1'b0;
         wr_done   <= 1'b0;
      end else begin
         req_ready <= (nxt_state == ST_IDLE);
         mem_cs_n  <= !sel_d;
         mem_cs    <= sel_d;
         mem_we_n  <= (nxt_state != ST_WPULSE);
         mem_oe_n  <= (nxt_state != ST_RACC);
         mem_dq_oe <= (nxt_state == ST_WSET) || (nxt_state == ST_WPULSE);
         rd_valid  <= rd_capture;
         wr_done   <= wr_end;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr <= '0;
         mem_dq_o <= '0;
         rd_data  <= '0;
      end else begin
         if (accept) begin
            mem_addr <= req_addr;
            mem_dq_o <= req_wdata;
         end
         if (rd_capture) rd_data <= mem_dq_i;
      end
   end
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
   import sram_strobe_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8,
   parameter int T_ACC  = 7,
   parameter int T_WP   = 6,
   parameter int T_WREC = 1,
   parameter int T_TURN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              wr_done,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_cs,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);
   localparam int POST_WR = imax(T_WREC, T_TURN);
   localparam int T_MAX   = imax(imax(T_ACC, T_WP), POST_WR);
   localparam int CNT_W   = (T_MAX < 2) ? 1 : $clog2(T_MAX);

   generate
      if (T_ACC < 1 || T_WP < 1 || T_WREC < 1 || T_TURN < 1) begin : g_bad_timing
         $error("sram_strobe_ctrl: every timing window must be at least one cycle");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_strobe_ctrl: address and data widths must be positive");
      end
   endgenerate

   seq_state_t       nxt_state;
   logic             load, expired, accept, rd_capture, wr_end;
   logic [CNT_W-1:0] load_val;

   sram_win_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
      .expired(expired)
   );

   sram_seq_fsm #(
      .CNT_W(CNT_W), .T_ACC(T_ACC), .T_WP(T_WP),
      .POST_WR(POST_WR), .T_TURN(T_TURN)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .expired(expired), .nxt_state(nxt_state), .load(load),
      .load_val(load_val), .accept(accept), .rd_capture(rd_capture),
      .wr_end(wr_end)
   );

   sram_pin_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
      .clk(clk), .rst_n(rst_n), .nxt_state(nxt_state), .accept(accept),
      .rd_capture(rd_capture), .wr_end(wr_end), .req_addr(req_addr),
      .req_wdata(req_wdata), .mem_dq_i(mem_dq_i), .req_ready(req_ready),
      .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
      .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o),
      .mem_dq_oe(mem_dq_oe), .rd_data(rd_data), .rd_valid(rd_valid),
      .wr_done(wr_done)
   );
endmodule

// File: rtl/sram_strobe_chk.sv
module sram_strobe_chk #(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8,
   parameter int T_ACC  = 7,
   parameter int T_WP   = 6,
   parameter int T_TURN = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_cs_n,
   input logic              mem_cs,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic [DATA_W-1:0] mem_dq_o,
   input logic              mem_dq_oe,
   input logic              rd_valid,
   input logic              wr_done
);
   localparam int CMAX = (T_ACC > T_WP) ? T_ACC : T_WP;
   localparam int CW   = $clog2(CMAX + 2);

   logic [CW-1:0] we_cnt, oe_cnt, quiet_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_cnt    <= '0;
         oe_cnt    <= '0;
         quiet_cnt <= CW'(T_TURN);
      end else begin
         we_cnt <= !mem_we_n ? ((we_cnt == CW'(CMAX + 1)) ? we_cnt : we_cnt + 1'b1) : '0;
         oe_cnt <= !mem_oe_n ? ((oe_cnt == CW'(CMAX + 1)) ? oe_cnt : oe_cnt + 1'b1) : '0;
         if (mem_dq_oe || !mem_oe_n)         quiet_cnt <= '0;
         else if (quiet_cnt < CW'(T_TURN))   quiet_cnt <= quiet_cnt + 1'b1;
      end
   end

   p_idle_parked_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe));

   p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   p_addr_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));

   p_we_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> $past(mem_dq_oe && !mem_cs_n && mem_cs));

   p_wdata_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(mem_dq_oe)) |-> $stable(mem_dq_o));

   p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_cnt == CW'(T_WP)));

   p_drive_only_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_dq_oe);

   p_we_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_dq_oe);

   p_strobe_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n || !mem_oe_n) |-> (!mem_cs_n && mem_cs && (mem_we_n || mem_oe_n)));

   p_oe_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> (oe_cnt == CW'(T_ACC)));

   p_rdvalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ($rose(mem_oe_n) && $past(!rd_valid)));

   p_wrdone_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |-> ($rose(mem_we_n) && $past(!wr_done)));

   p_turn_before_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_oe_n) |-> (quiet_cnt >= CW'(T_TURN)));

   p_turn_before_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_dq_oe) |-> (quiet_cnt >= CW'(T_TURN)));
endmodule

bind sram_strobe_ctrl sram_strobe_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_ACC(T_ACC), .T_WP(T_WP), .T_TURN(T_TURN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
   .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o),
   .mem_dq_oe(mem_dq_oe), .rd_valid(rd_valid), .wr_done(wr_done)
);

// File: tb/sram_strobe_ctrl_test.sv
module sram_strobe_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int T_ACC   = 7;
   localparam int T_WP    = 6;
   localparam int T_WREC  = 1;
   localparam int T_TURN  = 3;
   localparam int POST_WR = (T_WREC > T_TURN) ? T_WREC : T_TURN;
   localparam int NVEC    = 8;
   // {write, addr[12:0], data[7:0]}
   localparam logic [21:0] VEC [NVEC] = '{
      {1'b1, 13'h0000, 8'h11}, {1'b1, 13'h1FFF, 8'hEE},
      {1'b0, 13'h0000, 8'h00}, {1'b0, 13'h1FFF, 8'h00},
      {1'b1, 13'h0AAA, 8'h55}, {1'b1, 13'h0AAA, 8'hA5},
      {1'b0, 13'h0AAA, 8'h00}, {1'b0, 13'h1555, 8'h00}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [12:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic req_ready, rd_valid, wr_done;
   logic [7:0] rd_data, mem_dq_o, mem_dq_i;
   logic [12:0] mem_addr;
   logic mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;

   int n_chk = 0, n_fail = 0, cyc = 0, viol = 0;
   bit finished = 1'b0;
   logic [7:0] shadow [int];

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_strobe_ctrl #(
      .T_ACC(T_ACC), .T_WP(T_WP), .T_WREC(T_WREC), .T_TURN(T_TURN)
   ) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .wr_done(wr_done),
      .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
      .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o),
      .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
   );

   // clocked behavioural memory: commits a write when the write condition ends,
   // and returns wrong data until output enable has lasted T_ACC cycles
   logic [7:0] model_mem [int];
   logic wr_pend = 1'b0;
   logic [12:0] wr_a = '0;
   logic [7:0] wr_d = '0, rd_word = '0;
   int rd_cnt = 0;
   logic rd_act;
   assign rd_act   = !mem_cs_n && mem_cs && mem_we_n && !mem_oe_n;
   assign mem_dq_i = (rd_act && (rd_cnt + 1 >= T_ACC)) ? rd_word : ~rd_word;

   always @(posedge clk) begin
      if (!mem_cs_n && mem_cs && !mem_we_n) begin
         wr_pend <= 1'b1;
         wr_a    <= mem_addr;
         wr_d    <= mem_dq_o;
         if (!mem_dq_oe || !mem_oe_n) viol++;
      end else if (wr_pend) begin
         model_mem[int'(wr_a)] = wr_d;
         wr_pend <= 1'b0;
      end
      if (rd_act) begin
         rd_cnt <= rd_cnt + 1;
         if (mem_dq_oe) viol++;
      end else rd_cnt <= 0;
      rd_word <= model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'h00;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic chk_idle(input string tag);
      chk(mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe, tag,
          {mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
   endtask

   task automatic do_write(input logic [12:0] a, input logic [7:0] d, input bit poke);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R2 ready low after accept", req_ready, 0);
      chk(mem_addr == a, "R3 address captured", mem_addr, a);
      chk(!mem_cs_n && mem_cs && mem_we_n && mem_oe_n, "R4 setup strobes",
          {mem_cs_n, mem_cs, mem_we_n, mem_oe_n}, 4'b0111);
      chk(mem_dq_oe && mem_dq_o == d, "R4 setup data driven", {mem_dq_oe, mem_dq_o}, {1'b1, d});
      for (int k = 1; k <= T_WP; k++) begin
         @(negedge clk);
         chk(!mem_we_n && mem_oe_n, "R4 write pulse", {mem_we_n, mem_oe_n}, 2'b01);
         chk(mem_dq_oe && mem_dq_o == d, "R5 data driven during pulse", mem_dq_o, d);
         chk(mem_addr == a, "R3 address held", mem_addr, a);
         if (poke && k == 1) begin
            req_valid = 1'b1; req_write = 1'b1; req_addr = ~a; req_wdata = ~d;
         end else req_valid = 1'b0;
      end
      @(negedge clk);
      req_valid = 1'b0;
      chk(wr_done, "R8 done pulse", wr_done, 1);
      chk(mem_we_n && !mem_dq_oe, "R5 bus released after pulse", {mem_we_n, mem_dq_oe}, 2'b10);
      for (int k = 1; k < POST_WR; k++) begin
         @(negedge clk);
         chk(!req_ready, "R9 recovery busy", req_ready, 0);
         chk(!wr_done, "R8 single done", wr_done, 0);
         chk(mem_addr == a, "R3 address held in recovery", mem_addr, a);
      end
      @(negedge clk);
      chk(req_ready, "R9 ready after recovery", req_ready, 1);
      chk_idle("R1 parked after write");
      shadow[int'(a)] = d;
   endtask

   task automatic do_read(input logic [12:0] a);
      logic [7:0] exp;
      exp = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      chk(mem_addr == a, "R3 read address", mem_addr, a);
      for (int k = 1; k <= T_ACC; k++) begin
         chk(!mem_oe_n && !mem_cs_n && mem_cs && mem_we_n, "R7 output enable window",
             {mem_oe_n, mem_cs_n, mem_cs, mem_we_n}, 4'b0011);
         chk(!mem_dq_oe, "R5 bus not driven in read", mem_dq_oe, 0);
         chk(!rd_valid, "R7 no early valid", rd_valid, 0);
         @(negedge clk);
      end
      chk(rd_valid && mem_oe_n, "R7 valid pulse", {rd_valid, mem_oe_n}, 2'b11);
      chk(rd_data == exp, "R7 read data", rd_data, exp);
      for (int k = 1; k < T_TURN; k++) begin
         @(negedge clk);
         chk(!req_ready && !rd_valid, "R9 turnaround busy", {req_ready, rd_valid}, 2'b00);
         chk_idle("R9 strobes quiet in turnaround");
      end
      @(negedge clk);
      chk(req_ready && !rd_valid, "R9 ready after turnaround", {req_ready, rd_valid}, 2'b10);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk_idle("R1 strobes during reset");
      chk(!rd_valid && !wr_done, "R1 pulses low in reset", {rd_valid, wr_done}, 2'b00);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready, "R1 ready after reset", req_ready, 1);
      chk_idle("R1 parked after reset");

      for (int i = 0; i < NVEC; i++) begin
         if (VEC[i][21]) do_write(VEC[i][20:8], VEC[i][7:0], 1'b0);
         else            do_read(VEC[i][20:8]);
      end

      // R2: a request raised mid-write is ignored; its address stays untouched
      do_write(13'h0123, 8'h3C, 1'b1);
      do_read(13'h0123);
      do_read(~13'h0123);

      // R2: no request, nothing moves
      repeat (5) begin
         @(negedge clk);
         chk_idle("R2 idle without request");
      end

      // read straight after read, then write straight after read (turnaround)
      do_read(13'h1FFF);
      do_write(13'h1FFF, 8'h81, 1'b0);
      do_read(13'h1FFF);

      for (int i = 0; i < 12; i++) begin
         logic [12:0] a;
         logic [7:0]  d;
         a = 13'($urandom);
         d = 8'($urandom);
         do_write(a, d, 1'b0);
         do_read(a);
      end

      chk(viol == 0, "R6 model saw strobe overlap violations", viol, 0);
      finished = 1'b1;
      summary();
      $finish;
   end
endmodule